// File: doc/BRIEF.md
# Raw Track Image Stream Parser

This block parses a raw track image delivered as a serial stream of coded bits, one bit per accepted transfer. The bits come MSB-first from 36-bit words. The parser finds the inter-sector gap, checks a fixed sync preamble, and hands the header and sector fields to a 3-to-2 coded-bit decoder. It counts coded bits so that it knows where each field ends. The decoder rebuilds 36-bit data words, and each one is offered on an output stream tagged as a header word or a sector word.

The sector length is not fixed. It comes from a complemented 14-bit field in the second header word and is checked against a limit. The fields of the first header word are held on output pins. Record-length, framing and coding errors are sticky flags. A one-cycle `start` pulse restarts the parser.

Both data interfaces use valid/ready. An input bit is consumed in a cycle where `bit_valid` and `bit_ready` are both high. A word is consumed in a cycle where `word_valid` and `word_ready` are both high. While a word is waiting to be taken, the parser holds that word and takes no new bits. Back-pressure on the output therefore passes straight through to the input.

Top module: `track_image_parser`

## Requirements
- R1: After reset or a `start` pulse, `phase` is 0 (gap), `len_err`, `frame_err` and `code_err` are 0, `word_valid` is 0 and `bit_ready` is 1. The decoder history is also restarted. The `phase` codes are: 0 gap, 1 preamble, 2 header, 3 postamble, 4 marker, 5 sector, 6 error.
- R2: In the gap, a 1 bit keeps the phase at gap. The first 0 bit moves it to preamble.
- R3: The preamble is 40 bits of the pattern 1,0,1,0,1 repeated. After the 40th correct bit the phase becomes header. Any wrong bit moves the phase to error and sets `frame_err`.
- R4: The header is 108 coded bits, which decode to two words with `word_is_sector`=0. The first header word is shown on pins: key from bits 35:28, cylinder from 27:19, surface from 18:14, sector from 13:8, flags {indirect, software protect, hardware protect} from bits 7,6,5, spare from 4:2, and parity from 1:0.
- R5: At the end of the header, `sector_len` = 16384 minus bits 29:16 of the second header word, computed as a 15-bit value.
- R6: If that length is greater than `LEN_LIMIT`, `len_err` is set and the phase goes straight to sector, skipping the postamble and marker.
- R7: Otherwise the phase becomes postamble. It waits there for the first 0 bit and then enters the marker phase. In the marker phase, a 1 bit enters sector and a 0 bit enters error and sets `frame_err`.
- R8: The sector field is (`sector_len`+2)×54 coded bits, which decode to `sector_len`+2 words with `word_is_sector`=1. After its last bit the phase returns to gap.
- R9: The error phase consumes every further bit and produces no words until `start` is pulsed.
- R10: Coded bits are decoded three at a time into two data bits, filled into words from the MSB. Let p be the last coded bit of the previous group (1 after restart). If p=1: 011→01, 101→10, 111→11, 110→00, 010→00. If p=0: 101→{f,0} and 111→{f,1}, where f is the first bit of the previous group. Any other group sets `code_err` and yields 00.
- R11: While `word_valid`=1 and `word_ready`=0, `word_data` and `word_is_sector` hold steady and `bit_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Synchronous restart pulse |
| bit_valid | input | 1 | Input coded bit present |
| bit_ready | output | 1 | Parser accepts a bit this cycle |
| bit_in | input | 1 | Coded bit value |
| word_valid | output | 1 | Decoded word present |
| word_ready | input | 1 | Consumer takes the word |
| word_data | output | 36 | Decoded word |
| word_is_sector | output | 1 | 1 for a sector word, 0 for a header word |
| phase | output | 3 | Current parser phase (codes in R1) |
| len_err | output | 1 | Sticky record-length error |
| frame_err | output | 1 | Sticky framing error |
| code_err | output | 1 | Sticky coding error |
| sector_len | output | 15 | Sector data length in words |
| hdr_key | output | 8 | Header key field |
| hdr_cyl | output | 9 | Header cylinder |
| hdr_surf | output | 5 | Header surface |
| hdr_sect | output | 6 | Header sector |
| hdr_flags | output | 3 | Indirect, software protect, hardware protect |
| hdr_spare | output | 3 | Header bits 4:2 |
| hdr_parity | output | 2 | Header parity bits |

## Verification
The bench runs frames with several gap lengths, including a gap of zero ones. Their sector lengths are 1, 2, 3, exactly the limit, and one above the limit. An off-by-one in the length compare or in the checksum-word allowance shows up as a wrong word count or a wrong final phase. A design that still waits for the postamble after an over-length header stays in phase 3 instead of phase 5. The bench checks the preamble edge: still phase 1 after 39 bits, phase 2 after 40. A bad preamble bit must land in error and stay there under further traffic. A 0 marker bit must also be caught. An illegal coded group must raise `code_err`. A stall on `word_ready` must freeze both the word and `bit_ready`; a design that drops or overwrites a word under back-pressure loses data in the captured stream.

// File: rtl/tip_pkg.sv
package tip_pkg;
  typedef enum logic [2:0] {
    PH_GAP  = 3'd0,
    PH_PRE  = 3'd1,
    PH_HDR  = 3'd2,
    PH_POST = 3'd3,
    PH_MARK = 3'd4,
    PH_SECT = 3'd5,
    PH_ERR  = 3'd6
  } phase_e;

  localparam int WORD_W      = 36;
  localparam int CODED_WORD  = (WORD_W / 2) * 3;
  localparam int HDR_WORDS   = 2;
  localparam int HDR_BITS    = HDR_WORDS * CODED_WORD;
  localparam int PRE_PERIOD  = 5;
  localparam int PRE_REPEATS = 8;
  localparam int PRE_BITS    = PRE_PERIOD * PRE_REPEATS;
  localparam int LEN_LSB     = 16;
  localparam int LEN_FW      = 14;
  localparam int LEN_W       = LEN_FW + 1;
  localparam int CKSUM_WORDS = 2;
  localparam int CNT_W       = $clog2(((1 << LEN_FW) + CKSUM_WORDS) * CODED_WORD + 1);
endpackage

// File: rtl/tip_fm_decode.sv
module tip_fm_decode
  import tip_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift,
  input  logic              bit_in,
  output logic              word_done,
  output logic [WORD_W-1:0] word_out,
  output logic              code_bad
);
  localparam int PAIRS = WORD_W / 2;
  localparam int PW    = $clog2(PAIRS);

  logic [4:0]        hist;
  logic [1:0]        grp;
  logic [WORD_W-1:0] acc;
  logic [PW-1:0]     npair;
  logic [5:0]        h;
  logic [1:0]        pair;
  logic              legal;
  logic              grp_full;

  assign h        = {hist, bit_in};
  assign grp_full = (grp == 2'd2);

  always_comb begin
    legal = 1'b1;
    pair  = 2'b00;
    unique case (h[3:0])
      4'h5, 4'h7:        pair = {h[5], h[1]};
      4'hA, 4'hE:        pair = 2'b00;
      4'hB, 4'hD, 4'hF:  pair = h[2:1];
      default:           legal = 1'b0;
    endcase
  end

  assign word_out  = {acc[WORD_W-3:0], pair};
  assign word_done = shift && grp_full && (npair == PW'(PAIRS - 1));
  assign code_bad  = shift && grp_full && !legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist  <= 5'b00001;
      grp   <= '0;
      acc   <= '0;
      npair <= '0;
    end else if (clr) begin
      hist  <= 5'b00001;
      grp   <= '0;
      acc   <= '0;
      npair <= '0;
    end else if (shift) begin
      hist <= h[4:0];
      if (grp_full) begin
        grp <= '0;
        if (word_done) begin
          acc   <= '0;
          npair <= '0;
        end else begin
          acc   <= word_out;
          npair <= npair + 1'b1;
        end
      end else begin
        grp <= grp + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tip_framer.sv
module tip_framer
  import tip_pkg::*;
#(
  parameter int LEN_LIMIT = 1028
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              take,
  input  logic              bit_in,
  input  logic              dec_done,
  input  logic [WORD_W-1:0] dec_word,
  output phase_e            phase,
  output logic              feed,
  output logic              len_err,
  output logic              frame_err,
  output logic [LEN_W-1:0]  sector_len,
  output logic [WORD_W-1:0] hdr_word
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] total;
  logic [2:0]       pidx;
  logic [LEN_W-1:0] new_len;
  logic [CNT_W-1:0] new_total;
  logic             pre_bit;

  assign feed      = take && (phase == PH_HDR || phase == PH_SECT);
  assign new_len   = LEN_W'(1 << LEN_FW) - LEN_W'(dec_word[LEN_LSB +: LEN_FW]);
  assign new_total = (CNT_W'(new_len) + CNT_W'(CKSUM_WORDS)) * CNT_W'(CODED_WORD);
  assign pre_bit   = ~pidx[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_GAP;
      cnt        <= '0;
      total      <= '0;
      pidx       <= '0;
      len_err    <= 1'b0;
      frame_err  <= 1'b0;
      sector_len <= '0;
      hdr_word   <= '0;
    end else if (start) begin
      phase     <= PH_GAP;
      cnt       <= '0;
      total     <= '0;
      pidx      <= '0;
      len_err   <= 1'b0;
      frame_err <= 1'b0;
    end else if (take) begin
      unique case (phase)
        PH_GAP: if (!bit_in) begin
          phase <= PH_PRE;
          cnt   <= '0;
          pidx  <= '0;
        end
        PH_PRE: begin
          if (bit_in != pre_bit) begin
            phase     <= PH_ERR;
            frame_err <= 1'b1;
          end else begin
            pidx <= (pidx == 3'(PRE_PERIOD - 1)) ? 3'd0 : pidx + 3'd1;
            if (cnt == CNT_W'(PRE_BITS - 1)) begin
              phase <= PH_HDR;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PH_HDR: begin
          if (dec_done && cnt == CNT_W'(CODED_WORD - 1)) hdr_word <= dec_word;
          if (cnt == CNT_W'(HDR_BITS - 1)) begin
            sector_len <= new_len;
            total      <= new_total;
            cnt        <= '0;
            if (int'(new_len) > LEN_LIMIT) begin
              len_err <= 1'b1;
              phase   <= PH_SECT;
            end else begin
              phase <= PH_POST;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_POST: if (!bit_in) phase <= PH_MARK;
        PH_MARK: begin
          if (bit_in) begin
            phase <= PH_SECT;
          end else begin
            phase     <= PH_ERR;
            frame_err <= 1'b1;
          end
        end
        PH_SECT: begin
          if (cnt == total - 1'b1) begin
            phase <= PH_GAP;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: phase <= PH_ERR;
      endcase
    end
  end
endmodule

// File: rtl/track_image_parser.sv
module track_image_parser
  import tip_pkg::*;
#(
  parameter int LEN_LIMIT = 1028
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              bit_valid,
  output logic              bit_ready,
  input  logic              bit_in,
  output logic              word_valid,
  input  logic              word_ready,
  output logic [WORD_W-1:0] word_data,
  output logic              word_is_sector,
  output logic [2:0]        phase,
  output logic              len_err,
  output logic              frame_err,
  output logic              code_err,
  output logic [LEN_W-1:0]  sector_len,
  output logic [7:0]        hdr_key,
  output logic [8:0]        hdr_cyl,
  output logic [4:0]        hdr_surf,
  output logic [5:0]        hdr_sect,
  output logic [2:0]        hdr_flags,
  output logic [2:0]        hdr_spare,
  output logic [1:0]        hdr_parity
);
  logic              take;
  logic              feed;
  logic              dec_done;
  logic              code_bad;
  logic [WORD_W-1:0] dec_word;
  logic [WORD_W-1:0] hdr_word;
  phase_e            ph;

  assign bit_ready = !word_valid || word_ready;
  assign take      = bit_valid && bit_ready;
  assign phase     = ph;

  tip_framer #(.LEN_LIMIT(LEN_LIMIT)) u_framer (
    .clk(clk), .rst_n(rst_n), .start(start), .take(take), .bit_in(bit_in),
    .dec_done(dec_done), .dec_word(dec_word), .phase(ph), .feed(feed),
    .len_err(len_err), .frame_err(frame_err), .sector_len(sector_len),
    .hdr_word(hdr_word)
  );

  tip_fm_decode u_dec (
    .clk(clk), .rst_n(rst_n), .clr(start), .shift(feed), .bit_in(bit_in),
    .word_done(dec_done), .word_out(dec_word), .code_bad(code_bad)
  );

  assign hdr_key    = hdr_word[35:28];
  assign hdr_cyl    = hdr_word[27:19];
  assign hdr_surf   = hdr_word[18:14];
  assign hdr_sect   = hdr_word[13:8];
  assign hdr_flags  = hdr_word[7:5];
  assign hdr_spare  = hdr_word[4:2];
  assign hdr_parity = hdr_word[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_valid     <= 1'b0;
      word_data      <= '0;
      word_is_sector <= 1'b0;
      code_err       <= 1'b0;
    end else if (start) begin
      word_valid <= 1'b0;
      code_err   <= 1'b0;
    end else begin
      if (word_valid && word_ready) word_valid <= 1'b0;
      if (dec_done) begin
        word_valid     <= 1'b1;
        word_data      <= dec_word;
        word_is_sector <= (ph == PH_SECT);
      end
      if (code_bad) code_err <= 1'b1;
    end
  end
endmodule

// File: rtl/tip_checker.sv
module tip_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        bit_valid,
  input logic        bit_ready,
  input logic        bit_in,
  input logic        word_valid,
  input logic        word_ready,
  input logic [35:0] word_data,
  input logic        word_is_sector,
  input logic [2:0]  phase,
  input logic        len_err,
  input logic        frame_err,
  input logic        code_err
);
  assert_phase_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= 3'd6);

  assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (phase == 3'd0 && !len_err && !frame_err && !code_err && !word_valid));

  assert_marker_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd4 && bit_valid && bit_ready && !bit_in && !start) |=> (phase == 3'd6 && frame_err));

  assert_error_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd6 && !start) |=> (phase == 3'd6 && !word_valid));

  assert_len_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (len_err && !start) |=> len_err);

  assert_hold_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready && !start) |=> (word_valid && $stable(word_data) && $stable(word_is_sector)));

  assert_stall_input_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready) |-> !bit_ready);
endmodule

bind track_image_parser tip_checker u_tip_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .bit_valid(bit_valid),
  .bit_ready(bit_ready), .bit_in(bit_in), .word_valid(word_valid),
  .word_ready(word_ready), .word_data(word_data), .word_is_sector(word_is_sector),
  .phase(phase), .len_err(len_err), .frame_err(frame_err), .code_err(code_err)
);

// File: tb/test_track_image_parser.sv
module test_track_image_parser;
  localparam int LIMIT = 8;
  localparam int NV = 5;
  localparam int LEN_TAB [NV] = '{1, 2, 3, 8, 9};
  localparam int GAP_TAB [NV] = '{3, 0, 10, 1, 4};
  localparam bit OVR_TAB [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic [3:0] DIG [9] = '{4'h5, 4'h6, 4'h7, 4'h9, 4'hA, 4'hB, 4'hD, 4'hE, 4'hF};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic bit_valid = 1'b0, bit_in = 1'b0, word_ready = 1'b1;
  logic bit_ready, word_valid, word_is_sector, len_err, frame_err, code_err;
  logic [35:0] word_data;
  logic [2:0] phase;
  logic [14:0] sector_len;
  logic [7:0] hdr_key;
  logic [8:0] hdr_cyl;
  logic [4:0] hdr_surf;
  logic [5:0] hdr_sect;
  logic [2:0] hdr_flags, hdr_spare;
  logic [1:0] hdr_parity;

  int total = 0, bad = 0, cap_n = 0;
  logic [35:0] cap_d [64];
  logic        cap_s [64];
  logic        enc_prev = 1'b1;
  logic [35:0] exp_w [16];

  always #10 clk = ~clk;

  track_image_parser #(.LEN_LIMIT(LIMIT)) i_track_image_parser (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_valid(bit_valid),
    .bit_ready(bit_ready), .bit_in(bit_in), .word_valid(word_valid),
    .word_ready(word_ready), .word_data(word_data), .word_is_sector(word_is_sector),
    .phase(phase), .len_err(len_err), .frame_err(frame_err), .code_err(code_err),
    .sector_len(sector_len), .hdr_key(hdr_key), .hdr_cyl(hdr_cyl),
    .hdr_surf(hdr_surf), .hdr_sect(hdr_sect), .hdr_flags(hdr_flags),
    .hdr_spare(hdr_spare), .hdr_parity(hdr_parity)
  );

  always @(posedge clk) begin
    if (word_valid && word_ready && cap_n < 64) begin
      cap_d[cap_n] <= word_data;
      cap_s[cap_n] <= word_is_sector;
      cap_n <= cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_in = b;
    bit_valid = 1'b1;
    while (!bit_ready) @(negedge clk);
    @(posedge clk);
    #1 bit_valid = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    enc_prev = 1'b1;
    cap_n = 0;
  endtask

  // coded group for one data pair (R10), following the previous coded bit
  task automatic send_pair(input logic [1:0] p);
    logic [2:0] g;
    if (enc_prev) begin
      case (p)
        2'b00: g = 3'b110;
        2'b01: g = 3'b011;
        2'b10: g = 3'b101;
        default: g = 3'b111;
      endcase
    end else begin
      g = p[0] ? 3'b111 : 3'b101;
    end
    for (int k = 2; k >= 0; k--) send_bit(g[k]);
    enc_prev = g[0];
  endtask

  task automatic send_word(input logic [35:0] w);
    for (int k = 17; k >= 0; k--) send_pair(w[2*k +: 2]);
  endtask

  task automatic send_preamble(input int nbits);
    for (int i = 0; i < nbits; i++) send_bit(((i % 5) % 2) == 0);
  endtask

  function automatic logic [35:0] mk_word(input int i);
    logic [35:0] w;
    for (int n = 0; n < 9; n++) w[4*n +: 4] = DIG[(i * 3 + n * 7) % 9];
    return w;
  endfunction

  function automatic logic [35:0] hdr1();
    return {8'hDB, 9'h177, 5'h13, 6'h1B, 1'b1, 1'b0, 1'b1, 3'b111, 2'b10};
  endfunction

  function automatic logic [35:0] hdr2(input int len);
    return {6'h3F, 14'(16384 - len), 16'hFFFF};
  endfunction

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(phase == 3'd0, "R1 reset phase", phase, 0);
    chk(!len_err && !frame_err && !code_err, "R1 reset flags", {len_err, frame_err, code_err}, 0);
    chk(!word_valid && bit_ready, "R1 reset handshake", {word_valid, bit_ready}, 1);

    // table of frames: gap length, sector length, over-limit expectation
    for (int v = 0; v < NV; v++) begin
      int len, nexp;
      len = LEN_TAB[v];
      pulse_start();
      for (int g = 0; g < GAP_TAB[v]; g++) send_bit(1'b1);
      chk(phase == 3'd0, "R2 gap holds on ones", phase, 0);
      send_bit(1'b0);
      send_preamble(40);
      send_word(hdr1());
      send_word(hdr2(len));
      chk(sector_len == 15'(len), "R5 sector length", sector_len, len);
      chk(len_err == OVR_TAB[v], "R6 length error flag", len_err, OVR_TAB[v]);
      chk(phase == (OVR_TAB[v] ? 3'd5 : 3'd3), "R6 R7 phase after header", phase,
          OVR_TAB[v] ? 5 : 3);
      if (!OVR_TAB[v]) begin
        for (int p = 0; p < v + 1; p++) send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        chk(phase == 3'd5, "R7 marker enters sector", phase, 5);
      end
      exp_w[0] = hdr1();
      exp_w[1] = hdr2(len);
      for (int i = 0; i < len + 2; i++) begin
        exp_w[i + 2] = mk_word(i + v);
        send_word(mk_word(i + v));
      end
      chk(phase == 3'd0, "R8 back to gap after sector", phase, 0);
      repeat (3) @(negedge clk);
      nexp = len + 4;
      chk(cap_n == nexp, "R8 word count", cap_n, nexp);
      for (int i = 0; i < nexp && i < cap_n; i++) begin
        chk(cap_d[i] == exp_w[i], "R10 decoded word", cap_d[i], exp_w[i]);
        chk(cap_s[i] == (i >= 2), "R4 R8 word tag", cap_s[i], i >= 2);
      end
      chk(hdr_key == 8'hDB && hdr_cyl == 9'h177 && hdr_surf == 5'h13 && hdr_sect == 6'h1B,
          "R4 header fields", {hdr_key, hdr_cyl, hdr_surf, hdr_sect}, {8'hDB, 9'h177, 5'h13, 6'h1B});
      chk(hdr_flags == 3'b101 && hdr_spare == 3'b111 && hdr_parity == 2'b10,
          "R4 header flags", {hdr_flags, hdr_spare, hdr_parity}, {3'b101, 3'b111, 2'b10});
      chk(!frame_err && !code_err, "R3 R10 no error on clean frame", {frame_err, code_err}, 0);
    end

    // preamble boundary: 39 bits still preamble, 40th enters header (R3)
    pulse_start();
    send_bit(1'b0);
    chk(phase == 3'd1, "R2 zero enters preamble", phase, 1);
    send_preamble(39);
    chk(phase == 3'd1, "R3 preamble after 39", phase, 1);
    send_bit(1'b1);
    chk(phase == 3'd2, "R3 header after 40", phase, 2);

    // illegal coded group (R10)
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    chk(code_err == 1'b1, "R10 illegal group flagged", code_err, 1);

    // preamble mismatch, then error absorbs traffic (R3, R9), start clears (R1)
    pulse_start();
    chk(!code_err && phase == 3'd0, "R1 start clears", {code_err, phase}, 0);
    send_bit(1'b0);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    chk(phase == 3'd6 && frame_err, "R3 preamble mismatch", {phase, frame_err}, 13);
    for (int i = 0; i < 300; i++) send_bit(i[0] ^ i[2]);
    repeat (3) @(negedge clk);
    chk(phase == 3'd6 && cap_n == 0, "R9 error absorbs bits", {phase, 8'(cap_n)}, 12'h600);
    pulse_start();
    chk(phase == 3'd0 && !frame_err, "R1 start leaves error", {phase, frame_err}, 0);

    // marker bit of 0 is a framing error (R7)
    send_bit(1'b1); send_bit(1'b0);
    send_preamble(40);
    send_word(hdr1());
    send_word(hdr2(1));
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    chk(phase == 3'd4, "R7 postamble zero enters marker", phase, 4);
    send_bit(1'b0);
    chk(phase == 3'd6 && frame_err, "R7 marker zero is error", {phase, frame_err}, 13);

    // back-pressure (R11)
    pulse_start();
    word_ready = 1'b0;
    send_bit(1'b0);
    send_preamble(40);
    send_word(hdr1());
    @(negedge clk);
    chk(word_valid && !bit_ready, "R11 stall input", {word_valid, bit_ready}, 2);
    repeat (4) @(negedge clk);
    chk(word_valid && word_data == hdr1() && !word_is_sector, "R11 word held", word_data, hdr1());
    word_ready = 1'b1;
    send_word(hdr2(2));
    repeat (3) @(negedge clk);
    chk(cap_n == 2 && cap_d[0] == hdr1() && cap_d[1] == hdr2(2), "R11 no word lost", cap_n, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule